// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matcher

This block computes one matching per time slot for an N-by-N crossbar. A start strobe captures an N-by-N occupancy matrix: bit `i*N+j` set means input `i` holds at least one cell for output `j`. The block then runs up to a fixed number of request/grant rounds, one round per clock cycle. In each round, every input that is still free names a single output. Every output that is still free then accepts one of the inputs that named it. Each accepted pair is added to the result.

Every input keeps a request pointer and every output keeps a grant pointer. The pointers live across slots. Because they move only under the conditions given below, they drift apart under heavy load and conflicts fade away. A done strobe marks the end of a slot. The result matrix then stays fixed until the next start is accepted.

Top module: `rr_xbar_matcher`

## Requirements
- R1: After reset, `grant_mat`, `done` and `busy` are zero, and every request and grant pointer is zero.
- R2: In each round, each free input names exactly one output: the first output, searching upward from its request pointer and wrapping modulo N, for which its captured bit is set and which is still free. An input with no such output names nothing.
- R3: Each free output accepts the first input that named it, searching upward from its grant pointer and wrapping modulo N.
- R4: An input's request pointer advances by one modulo N only when that input is accepted in the first round of a slot. It does not move in any other case.
- R5: An output's grant pointer advances by one modulo N each time that output accepts an input, in any round.
- R6: An input or output paired in one round takes no part in later rounds of the same slot, and pairs once added are never removed.
- R7: A slot ends after the round that adds no new pair, or after ITERS rounds, whichever comes first. `busy` is high from the cycle after start until that round completes. In the cycle after the last round, `done` is high for exactly one cycle and `busy` is low. With ITERS = log2(N) = 2 for N = 4, a full request matrix takes two rounds. An all-zero matrix takes one round.
- R8: `grant_mat` has at most one set bit in each row and each column. Every set bit is also set in the captured request matrix.
- R9: A start strobe that arrives while `busy` is high is ignored. The running slot is not disturbed.
- R10: Outside a running slot, `grant_mat` holds its value until the next accepted start. An accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a slot; sampled only while idle |
| req_mat | input | N*N | Occupancy matrix, bit i*N+j = input i has a cell for output j |
| grant_mat | output | N*N | Matching, bit i*N+j = input i paired with output j |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse after the final round |

## Verification
The assertions assume that `start` is a clean synchronous strobe and that `req_mat` is stable on the edge where a start is accepted. They place no constraint on `req_mat` at any other time, because the matrix is captured.

The stimulus drives `start` and `req_mat` only just after falling edges. It deliberately raises `start` while a slot is running, to exercise the ignore rule. It varies the occupancy matrix freely between slots, including all-zero, all-one and random patterns.

// File: rtl/rr_xbar_matcher.sv
module rr_xbar_matcher #(
  parameter int N     = 4,
  parameter int ITERS = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*N-1:0] req_mat,
  output logic [N*N-1:0] grant_mat,
  output logic           busy,
  output logic           done
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(ITERS + 1);

  logic [N-1:0][N-1:0]  reqm, gm;     // [input][output]
  logic [N-1:0]         in_m, out_m;
  logic [N-1:0][IW-1:0] rptr, gptr;
  logic [CW-1:0]        iter;
  logic [N-1:0][N-1:0]  rsel;         // [input][output] request of this round
  logic [N-1:0][N-1:0]  acc;          // [input][output] pairs added this round
  logic [N-1:0]         in_hit, out_hit;
  logic                 added, last;

  assign grant_mat = gm;

  always_comb begin
    rsel = '0;
    for (int i = 0; i < N; i++) begin
      logic found;
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
        int j;
        j = (int'(rptr[i]) + k) % N;
        if (!found && !in_m[i] && reqm[i][j] && !out_m[j]) begin
          rsel[i][j] = 1'b1;
          found = 1'b1;
        end
      end
    end
  end

  always_comb begin
    acc = '0;
    for (int o = 0; o < N; o++) begin
      logic found;
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
        int i;
        i = (int'(gptr[o]) + k) % N;
        if (!found && !out_m[o] && rsel[i][o]) begin
          acc[i][o] = 1'b1;
          found = 1'b1;
        end
      end
    end
  end

  always_comb begin
    in_hit  = '0;
    out_hit = '0;
    for (int i = 0; i < N; i++)
      for (int o = 0; o < N; o++)
        if (acc[i][o]) begin
          in_hit[i]  = 1'b1;
          out_hit[o] = 1'b1;
        end
  end

  assign added = |in_hit;
  assign last  = !added || (iter == CW'(ITERS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqm  <= '0;
      gm    <= '0;
      in_m  <= '0;
      out_m <= '0;
      rptr  <= '0;
      gptr  <= '0;
      iter  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          reqm  <= req_mat;
          gm    <= '0;
          in_m  <= '0;
          out_m <= '0;
          iter  <= '0;
          busy  <= 1'b1;
        end
      end else begin
        gm    <= gm | acc;
        in_m  <= in_m | in_hit;
        out_m <= out_m | out_hit;
        for (int o = 0; o < N; o++)
          if (out_hit[o]) gptr[o] <= IW'((int'(gptr[o]) + 1) % N);
        for (int i = 0; i < N; i++)
          if (in_hit[i] && iter == '0) rptr[i] <= IW'((int'(rptr[i]) + 1) % N);
        iter <= iter + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    logic [N-1:0] col;
    for (genvar h = 0; h < N; h++) begin : g_col
      assign col[h] = gm[h][g];
    end
    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gm[g])); // R8
    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col)); // R8
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $onehot0(rsel[g])); // R2
  end

  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (gm & ~reqm) == '0); // R8
  AST_PAIRS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (gm & $past(gm)) == $past(gm)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> iter < CW'(ITERS)); // R7
  AST_RPTR_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && iter != '0) |=> $stable(rptr)); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(reqm)); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(grant_mat)); // R10
endmodule

// File: tb/rr_xbar_matcher_bench.sv
module rr_xbar_matcher_bench;
  localparam int N = 4;
  localparam int ITERS = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [N*N-1:0] req_mat = '0;
  logic [N*N-1:0] grant_mat;
  logic busy, done;

  always #2.5 clk = ~clk;

  rr_xbar_matcher #(.N(N), .ITERS(ITERS)) u_rr_xbar_matcher (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mat(req_mat),
    .grant_mat(grant_mat), .busy(busy), .done(done));

  int checks = 0, failures = 0, cycles = 0;

  // behavioural reference
  int m_r[N], m_g[N], m_iter;
  bit m_in[N], m_out[N];
  bit [N*N-1:0] m_req, m_grant;
  bit m_busy, m_done;

  task automatic check(input bit ok, input string rq, input logic [N*N-1:0] act, input logic [N*N-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic model_round();
    int want[N];
    bit any;
    any = 0;
    foreach (want[i]) begin
      want[i] = -1;
      if (!m_in[i])
        for (int k = 0; k < N; k++) begin
          int j;
          j = (m_r[i] + k) % N;
          if (m_req[i*N+j] && !m_out[j]) begin want[i] = j; break; end
        end
    end
    for (int o = 0; o < N; o++) begin
      if (m_out[o]) continue;
      for (int k = 0; k < N; k++) begin
        int i;
        i = (m_g[o] + k) % N;
        if (want[i] == o) begin
          m_grant[i*N+o] = 1;
          m_in[i] = 1;
          m_out[o] = 1;
          m_g[o] = (m_g[o] + 1) % N;
          if (m_iter == 0) m_r[i] = (m_r[i] + 1) % N;
          any = 1;
          break;
        end
      end
    end
    m_iter++;
    if (!any || m_iter == ITERS) begin m_busy = 0; m_done = 1; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_r[i]) begin m_r[i] = 0; m_g[i] = 0; end
      m_grant = '0; m_busy = 0; m_done = 0; m_iter = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_req = req_mat; m_grant = '0; m_busy = 1; m_iter = 0;
          foreach (m_in[i]) begin m_in[i] = 0; m_out[i] = 0; end
        end
      end else model_round();
    end
  end

  // every-cycle comparison: R2 R3 R4 R5 R6 R7 R10
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(grant_mat === m_grant, "R2/R3/R4/R5/R6 grant_mat", grant_mat, m_grant);
      check({busy, done} === {m_busy, m_done}, "R7 busy/done", {busy, done}, {m_busy, m_done});
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic slot(input logic [N*N-1:0] m, output int rounds, output logic [N*N-1:0] res);
    @(negedge clk); #1;
    start = 1; req_mat = m;
    @(negedge clk); #1;
    start = 0; req_mat = ~m;
    rounds = 0;
    do begin @(negedge clk); rounds++; end while (!done && rounds < 20);
    res = grant_mat;
  endtask

  int rounds;
  logic [N*N-1:0] res;

  initial begin
    repeat (3) @(negedge clk);
    check({grant_mat, busy, done} === '0, "R1 reset outputs", grant_mat, '0);
    #1 rst_n = 1;
    @(negedge clk);
    check({grant_mat, busy, done} === '0, "R1 after release", grant_mat, '0);

    // full matrix, zero pointers: 0->0 then 1->1
    slot('1, rounds, res);
    check(res === 16'h0021, "R1 R2 R3 first full slot", res, 16'h0021);
    check(rounds == 2, "R7 full matrix takes ITERS rounds", rounds, 2);
    // pointers now R0=1,G0=1,G1=1: 0->1,1->0,2->2
    slot('1, rounds, res);
    check(res === 16'h0412, "R4 R5 R6 pointer movement", res, 16'h0412);

    slot('0, rounds, res);
    check(rounds == 1, "R7 empty matrix stops after one round", rounds, 1);
    check(res === '0, "R8 empty matrix no grants", res, '0);

    // start while busy is ignored
    @(negedge clk); #1;
    start = 1; req_mat = 16'h8421;
    @(negedge clk); #1;
    req_mat = 16'h1248;
    @(negedge clk); #1;
    start = 0;
    @(negedge clk);
    check(!busy, "R9 slot not restarted", busy, 0);
    check((grant_mat & ~16'h8421) === '0, "R9 result from first matrix", grant_mat, m_grant);
    repeat (4) @(negedge clk);
    check(grant_mat === m_grant, "R10 held after done", grant_mat, m_grant);

    for (int s = 0; s < 300; s++) begin
      logic [N*N-1:0] m;
      m = N*N'($urandom);
      if (s % 7 == 0) m = '1;
      slot(m, rounds, res);
      check((res & ~m) === '0, "R8 grants within requests", res, m);
      for (int r = 0; r < N; r++) begin
        int rc, cc;
        rc = 0; cc = 0;
        for (int c = 0; c < N; c++) begin rc += res[r*N+c]; cc += res[c*N+r]; end
        check(rc <= 1 && cc <= 1, "R8 one per row and column", res, m);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule